// File: doc/BRIEF.md
# Elapsed-Time Alarm Output Controller

This block watches a running elapsed-time count and compares it against a programmable alarm value. When the two become equal, and the alarm value is not zero, a sticky alarm flag is raised. The flag then drives an open-drain alarm pin. The block only produces the pull-down enable for that pin. The pin itself, and the level sensed back from it, live outside the block.

The pin has two output modes:
- **Steady mode:** the pin holds a level whose sense is chosen by a polarity bit.
- **Pulse mode:** the pin flashes a fixed burst of short low pulses separated by long high gaps. A burst plays only while the flag is set. It is started by any of these:
  - a power-up strobe,
  - the start of an event,
  - the end of an event,
  - the flag first rising while an event is in progress,
  - something outside pulling the pin low for a long enough time and then releasing it.

The pulse timing and the burst length are parameters, counted in clock cycles. The flag is cleared only by a dedicated clear input, driven by the counter-reset logic.

Top module: `alm_out_ctrl`

## Requirements
- R1: While the alarm value is zero, the alarm flag never sets, whatever the count is.
- R2: With a nonzero alarm value, the flag reads 1 from the first clock edge at which the count equals the alarm value. It reads 0 before that edge (after a clear).
- R3: Once set, the flag stays set when the count or the alarm value changes. Only `flag_clr` clears it. While `flag_clr` is high the flag reads 0, even if the count matches (clear wins over set).
- R4: In steady mode (`out_sel`=1) with `polarity`=0, `pin_pull` equals the flag: released before the match, pulling low from the match onward.
- R5: In steady mode with `polarity`=1, `pin_pull` is 1 while the alarm value is nonzero and the flag is clear, and 0 once the flag is set. With a zero alarm value, `pin_pull` is 0.
- R6: In pulse mode (`out_sel`=0) no pulse is produced while the flag is clear. The burst shape does not depend on `polarity`.
- R7: In pulse mode with the flag set, a one-cycle strobe on `pwr_up`, `event_start` or `event_end` starts a burst in the next cycle. A burst is exactly NUM_PULSES low pulses of LO_CYC cycles each, separated by GAP_CYC high cycles.
- R8: A rise of the flag while an event is active (after `event_start` and before `event_end`) starts a burst. A rise outside an event starts none.
- R9: A pulse-mode burst is also started when the sensed pin is held low from outside for at least REQ_CYC cycles and then released. A hold of REQ_CYC-1 cycles starts none. Cycles in which the block itself pulls the pin low are not counted.
- R10: A trigger that arrives during a burst is ignored. The running burst still ends after exactly NUM_PULSES pulses, and no extra pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| etc_val | input | CNT_W | Elapsed-time count |
| alarm_val | input | CNT_W | Alarm value; zero disables the alarm |
| out_sel | input | 1 | 1 = steady mode, 0 = pulse mode |
| polarity | input | 1 | Steady-mode level sense (0: low after match, 1: low before match) |
| event_start | input | 1 | One-cycle strobe at event start |
| event_end | input | 1 | One-cycle strobe at event end |
| pwr_up | input | 1 | One-cycle power-up strobe |
| pin_sense | input | 1 | Sensed level of the alarm pin (0 = low) |
| flag_clr | input | 1 | Clear of the alarm flag from the reset-command logic |
| pin_pull | output | 1 | Pull-down enable of the open-drain alarm pin |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The assertions take for granted three things about the stimulus:
- `out_sel` does not change while a pulse is on the pin.
- The strobes are single-cycle.
- `pin_sense` reflects the block's own pull-down in the same cycle.

The bench models the pin as a wired-AND of the block's pull and an external pull. It changes the mode only between bursts, after each 50-cycle observation window has let the previous burst finish. The count is raised one step per cycle, so that every value up to the alarm value is visited. This lets the bench predict the flag as the simple relation "count at or above the alarm value".

// File: rtl/alm_pkg.sv
package alm_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOW  = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_st_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/alm_flag.sv
module alm_flag #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] etc_val,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic             flag_clr,
  input  logic             event_start,
  input  logic             event_end,
  output logic             flag,
  output logic             alarm_nz,
  output logic             rise_evt
);

  logic flag_q, flag_d;
  logic flag_d1_q;
  logic evt_q, evt_d;
  logic hit;

  always_comb begin
    alarm_nz = |alarm_val;
    hit      = alarm_nz && (etc_val == alarm_val);
    if (flag_clr) flag_d = 1'b0;
    else          flag_d = flag_q | hit;
    if (event_start)    evt_d = 1'b1;
    else if (event_end) evt_d = 1'b0;
    else                evt_d = evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      flag_d1_q <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      flag_q    <= flag_d;
      flag_d1_q <= flag_q;
      evt_q     <= evt_d;
    end
  end

  assign flag     = flag_q;
  assign rise_evt = flag_q & ~flag_d1_q & evt_q;

endmodule

// File: rtl/alm_req_det.sv
module alm_req_det #(
  parameter int unsigned REQ_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sense,
  input  logic self_drive,
  output logic req
);

  localparam int unsigned CW = $clog2(REQ_CYC + 1);
  localparam logic [CW-1:0] REQ_V = CW'(REQ_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (self_drive || pin_sense) cnt_d = '0;
    else if (cnt_q != REQ_V)     cnt_d = cnt_q + 1'b1;
    else                         cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign req = pin_sense && !self_drive && (cnt_q == REQ_V);

endmodule

// File: rtl/alm_pulse_seq.sv
module alm_pulse_seq
  import alm_pkg::*;
#(
  parameter int unsigned LO_CYC     = 625,
  parameter int unsigned GAP_CYC    = 4375,
  parameter int unsigned NUM_PULSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic drive_lo,
  output logic busy
);

  localparam int unsigned MAXC = max2(LO_CYC, GAP_CYC);
  localparam int unsigned TW   = $clog2(MAXC + 1);
  localparam int unsigned PW   = $clog2(NUM_PULSES + 1);
  localparam logic [TW-1:0] LO_LAST  = TW'(LO_CYC - 1);
  localparam logic [TW-1:0] GAP_LAST = TW'(GAP_CYC - 1);
  localparam logic [PW-1:0] P_LAST   = PW'(NUM_PULSES - 1);

  seq_st_e       st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    pcnt_d = pcnt_q;
    case (st_q)
      SEQ_IDLE: begin
        if (trig) begin
          st_d   = SEQ_LOW;
          tmr_d  = '0;
          pcnt_d = '0;
        end
      end
      SEQ_LOW: begin
        if (tmr_q == LO_LAST) begin
          st_d  = SEQ_GAP;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      SEQ_GAP: begin
        if (tmr_q == GAP_LAST) begin
          tmr_d = '0;
          if (pcnt_q == P_LAST) begin
            st_d = SEQ_IDLE;
          end else begin
            st_d   = SEQ_LOW;
            pcnt_d = pcnt_q + 1'b1;
          end
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      tmr_q  <= '0;
      pcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign drive_lo = (st_q == SEQ_LOW);
  assign busy     = (st_q != SEQ_IDLE);

endmodule

// File: rtl/alm_out_ctrl.sv
module alm_out_ctrl #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned LO_CYC     = 625,
  parameter int unsigned GAP_CYC    = 4375,
  parameter int unsigned REQ_CYC    = 5000,
  parameter int unsigned NUM_PULSES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] etc_val,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic             out_sel,
  input  logic             polarity,
  input  logic             event_start,
  input  logic             event_end,
  input  logic             pwr_up,
  input  logic             pin_sense,
  input  logic             flag_clr,
  output logic             pin_pull,
  output logic             alarm_flag
);

  logic rst_sync_n;
  logic flag, alarm_nz, rise_evt;
  logic ext_req, seq_lo, seq_busy, seq_trig;
  logic steady_pull;

  alm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alm_flag #(.CNT_W(CNT_W)) u_flag (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .etc_val     (etc_val),
    .alarm_val   (alarm_val),
    .flag_clr    (flag_clr),
    .event_start (event_start),
    .event_end   (event_end),
    .flag        (flag),
    .alarm_nz    (alarm_nz),
    .rise_evt    (rise_evt)
  );

  alm_req_det #(.REQ_CYC(REQ_CYC)) u_req (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pin_sense  (pin_sense),
    .self_drive (pin_pull),
    .req        (ext_req)
  );

  always_comb begin
    seq_trig = ~out_sel & flag &
               (pwr_up | event_start | event_end | rise_evt | ext_req);
  end

  alm_pulse_seq #(
    .LO_CYC     (LO_CYC),
    .GAP_CYC    (GAP_CYC),
    .NUM_PULSES (NUM_PULSES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig     (seq_trig),
    .drive_lo (seq_lo),
    .busy     (seq_busy)
  );

  always_comb begin
    if (polarity) steady_pull = alarm_nz & ~flag;
    else          steady_pull = flag;
    pin_pull   = out_sel ? steady_pull : seq_lo;
    alarm_flag = flag;
  end

endmodule

// File: rtl/alm_out_ctrl_chk.sv
module alm_out_ctrl_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LO_CYC = 625
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] etc_val,
  input logic [CNT_W-1:0] alarm_val,
  input logic             out_sel,
  input logic             polarity,
  input logic             flag_clr,
  input logic             pin_pull,
  input logic             alarm_flag
);

  localparam int unsigned RW = $clog2(LO_CYC + 2);
  localparam logic [RW-1:0] RUN_SAT = RW'(LO_CYC + 1);

  logic [RW-1:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               lo_run <= '0;
    else if (pin_pull && !out_sel && lo_run != RUN_SAT) lo_run <= lo_run + 1'b1;
    else if (pin_pull && !out_sel)            lo_run <= lo_run;
    else                                      lo_run <= '0;
  end

  p_zero_alarm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && alarm_val == '0) |=> !alarm_flag);

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_val != '0 && etc_val == alarm_val && !flag_clr) |=> alarm_flag);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !flag_clr) |=> alarm_flag);

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !alarm_flag);

  p_steady_pol0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel && !polarity) |-> (pin_pull == alarm_flag));

  p_steady_pol1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel && polarity) |-> (pin_pull == ((alarm_val != '0) && !alarm_flag)));

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_sel && $past(!out_sel) && $fell(pin_pull)) |-> (lo_run == RW'(LO_CYC)));

endmodule

bind alm_out_ctrl alm_out_ctrl_chk #(
  .CNT_W  (CNT_W),
  .LO_CYC (LO_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .etc_val    (etc_val),
  .alarm_val  (alarm_val),
  .out_sel    (out_sel),
  .polarity   (polarity),
  .flag_clr   (flag_clr),
  .pin_pull   (pin_pull),
  .alarm_flag (alarm_flag)
);

// File: tb/alm_out_ctrl_tb_top.sv
module alm_out_ctrl_tb_top;

  localparam int CNT_W = 32;
  localparam int LO    = 3;
  localparam int GAP   = 5;
  localparam int REQ   = 6;
  localparam int NP    = 4;
  localparam int WIN   = 50;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] etc_val;
  logic [CNT_W-1:0] alarm_val;
  logic             out_sel, polarity, event_start, event_end, pwr_up;
  logic             flag_clr, ext_pull;
  logic             pin_sense, pin_pull, alarm_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  assign pin_sense = ~(pin_pull | ext_pull);

  alm_out_ctrl #(
    .CNT_W(CNT_W), .LO_CYC(LO), .GAP_CYC(GAP), .REQ_CYC(REQ), .NUM_PULSES(NP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .etc_val(etc_val), .alarm_val(alarm_val),
    .out_sel(out_sel), .polarity(polarity), .event_start(event_start),
    .event_end(event_end), .pwr_up(pwr_up), .pin_sense(pin_sense),
    .flag_clr(flag_clr), .pin_pull(pin_pull), .alarm_flag(alarm_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Observe WIN samples; count low pulses and verify their shape.
  // Optionally strobe event_end at sample index inj (inj < 0: none).
  task automatic watch(output int npulse, output bit shape_ok,
                       output int first, input int inj);
    bit prev = 1'b0;
    int lo = 0, hi = 0;
    npulse = 0; shape_ok = 1'b1; first = -1;
    for (int i = 0; i < WIN; i++) begin
      if (i > 0) @(negedge clk);
      event_end = (i == inj);
      if (pin_pull) begin
        if (!prev) begin
          npulse++;
          if (npulse == 1) first = i;
          else if (hi != GAP) shape_ok = 1'b0;
          lo = 0;
        end
        lo++;
      end else begin
        if (prev) begin
          if (lo != LO) shape_ok = 1'b0;
          hi = 0;
        end
        hi++;
      end
      prev = pin_pull;
    end
    event_end = 1'b0;
    if (prev) shape_ok = 1'b0;
  endtask

  task automatic strobe_burst(input int which, input string req, input string what);
    int n, f; bit ok;
    @(negedge clk);
    case (which)
      0: pwr_up = 1'b1;
      1: event_start = 1'b1;
      default: event_end = 1'b1;
    endcase
    @(negedge clk);
    pwr_up = 1'b0; event_start = 1'b0; event_end = 1'b0;
    watch(n, ok, f, -1);
    chk(n == NP, req, {what, " pulse count"}, n, NP);
    chk(ok, req, {what, " pulse shape"}, ok, 1);
    chk(f == 0, req, {what, " first low sample"}, f, 0);
  endtask

  task automatic do_clear();
    @(negedge clk);
    etc_val = '0; flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n, f; bit ok; bit reached; bit exp_pull;
    rst_n = 1'b0; etc_val = '0; alarm_val = '0; out_sel = 1'b0; polarity = 1'b0;
    event_start = 1'b0; event_end = 1'b0; pwr_up = 1'b0; flag_clr = 1'b0;
    ext_pull = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(alarm_flag == 1'b0, "R2", "reset flag", alarm_flag, 0);
    chk(pin_pull == 1'b0, "R6", "reset pin", pin_pull, 0);

    // R1: zero alarm never sets the flag; R5: zero alarm releases pin
    out_sel = 1'b1; polarity = 1'b1; alarm_val = '0;
    for (int e = 0; e < 8; e++) begin
      etc_val = e;
      @(negedge clk);
      chk(alarm_flag == 1'b0, "R1", "flag with zero alarm", alarm_flag, 0);
      chk(pin_pull == 1'b0, "R5", "pol1 pin with zero alarm", pin_pull, 0);
    end

    // R2/R4/R5: steady-mode sweep over polarity and alarm values
    for (int pol = 0; pol < 2; pol++) begin
      for (int a = 1; a <= 5; a++) begin
        polarity = pol[0]; alarm_val = a;
        do_clear();
        for (int e = 0; e < 8; e++) begin
          etc_val = e;
          @(negedge clk);
          reached  = (e >= a);
          exp_pull = pol[0] ? !reached : reached;
          chk(alarm_flag == reached, "R2", "flag in sweep", alarm_flag, reached);
          chk(pin_pull == exp_pull, pol[0] ? "R5" : "R4", "steady pin", pin_pull, exp_pull);
        end
      end
    end

    // R3: sticky and clear priority
    etc_val = 2; alarm_val = '0;
    repeat (3) @(negedge clk);
    chk(alarm_flag == 1'b1, "R3", "flag sticky after changes", alarm_flag, 1);
    alarm_val = 3; etc_val = 3; flag_clr = 1'b1;
    @(negedge clk);
    chk(alarm_flag == 1'b0, "R3", "clear wins over match", alarm_flag, 0);
    flag_clr = 1'b0;
    @(negedge clk);
    chk(alarm_flag == 1'b1, "R3", "set again after clear", alarm_flag, 1);

    // Pulse mode. R8: flag rise outside event gives no burst
    out_sel = 1'b0; polarity = 1'b0;
    do_clear();
    alarm_val = 3; etc_val = 3;
    watch(n, ok, f, -1);
    chk(alarm_flag == 1'b1, "R8", "flag set outside event", alarm_flag, 1);
    chk(n == 0, "R8", "no burst for rise outside event", n, 0);

    // R7: each strobe starts a burst
    strobe_burst(0, "R7", "power-up");
    strobe_burst(1, "R7", "event start");
    strobe_burst(2, "R7", "event end");

    // R6: polarity has no effect in pulse mode
    polarity = 1'b1;
    strobe_burst(0, "R6", "power-up with polarity 1");
    polarity = 1'b0;

    // R9: external pull long enough triggers, shorter does not
    @(negedge clk); ext_pull = 1'b1;
    repeat (REQ) @(negedge clk);
    ext_pull = 1'b0;
    watch(n, ok, f, -1);
    chk(n == NP, "R9", "external request pulse count", n, NP);
    chk(ok, "R9", "external request shape", ok, 1);
    @(negedge clk); ext_pull = 1'b1;
    repeat (REQ - 1) @(negedge clk);
    ext_pull = 1'b0;
    watch(n, ok, f, -1);
    chk(n == 0, "R9", "short external pull ignored", n, 0);

    // R10: trigger during burst ignored
    @(negedge clk); pwr_up = 1'b1;
    @(negedge clk); pwr_up = 1'b0;
    watch(n, ok, f, 10);
    chk(n == NP, "R10", "retrigger pulse count", n, NP);
    chk(ok, "R10", "retrigger shape", ok, 1);

    // R6: no pulses while flag clear
    do_clear();
    @(negedge clk); pwr_up = 1'b1;
    @(negedge clk); pwr_up = 1'b0;
    watch(n, ok, f, -1);
    chk(n == 0, "R6", "no burst with flag clear", n, 0);

    // R8: flag rise during event starts a burst
    alarm_val = 5;
    @(negedge clk); event_start = 1'b1;
    @(negedge clk); event_start = 1'b0;
    watch(n, ok, f, -1);
    chk(n == 0, "R6", "event start with flag clear", n, 0);
    for (int e = 0; e < 5; e++) begin
      etc_val = e;
      @(negedge clk);
    end
    etc_val = 5;
    watch(n, ok, f, -1);
    chk(n == NP, "R8", "rise in event pulse count", n, NP);
    chk(ok, "R8", "rise in event shape", ok, 1);
    chk(f == 2, "R8", "rise in event first low sample", f, 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule